// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts a slow, free-running tick (a single-cycle strobe in the system clock domain). An 8-bit base counter wraps once every 256 ticks. A postscaler counts those wraps and stretches the timeout by a power of two chosen by a 4-bit select. When the period runs out, the block asks for a device reset if the core is running, or sends a one-cycle wake-up pulse if the core is asleep.

Software must service the watchdog with a clear strobe before the timeout. Three other events also restart the count: entering sleep, a change of oscillator frequency and a clock failure. In window mode a service is accepted only once the base count has reached its top quarter. A service that comes earlier is treated as a fault and causes an immediate reset request. A read-only flag shows when the base count is in that top quarter. A hard enable keeps the watchdog running whatever the software enable says.

Top module: `wdog_win`

## Requirements
- R1: The watchdog runs when `hw_en` is 1 or `sw_en` is 1. When `hw_en` is 1, the value of `sw_en` has no effect.
- R2: While both enables are 0, the counters are held at zero. `rst_req` and `wake` stay 0, and `win_flag` reads 0. After re-enabling, a full period is needed before a timeout.
- R3: With `ps_sel` = n (0 to 15), a timeout happens on the tick numbered 256·2^n after the count last restarted. The output pulse appears one clock after that tick.
- R4: `win_flag` is 1 exactly when the watchdog is enabled and the base count (the number of ticks since the last restart, modulo 256) is 192 or more.
- R5: Each of `clr` (when accepted), `sleep_enter`, `freq_chg` and `clk_fail` restarts both the base counter and the postscaler at zero.
- R6: With `win_mode_n` = 0 (window mode), a `clr` while `win_flag` is 0 raises `rst_req` on the next clock and restarts the count. A `clr` while `win_flag` is 1 is accepted as a service.
- R7: With `win_mode_n` = 1, `clr` is accepted at any count and never raises `rst_req`.
- R8: On timeout with `asleep` = 0, `rst_req` pulses for one cycle. With `asleep` = 1, `wake` pulses for one cycle instead. Both outputs are never high together, and the count restarts after either pulse.
- R9: A restart event in the same cycle as the expiring tick wins, and no timeout pulse is produced, unless that event is a window violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow time-base strobe, one cycle wide |
| hw_en | input | 1 | Hard enable, overrides `sw_en` |
| sw_en | input | 1 | Software enable |
| ps_sel | input | 4 | Postscale select, ratio 2^ps_sel |
| win_mode_n | input | 1 | 0 selects window mode |
| clr | input | 1 | Service strobe |
| sleep_enter | input | 1 | Sleep-entry strobe |
| freq_chg | input | 1 | Oscillator frequency change strobe |
| clk_fail | input | 1 | Clock failure strobe |
| asleep | input | 1 | Core is in sleep |
| rst_req | output | 1 | One-cycle reset request |
| wake | output | 1 | One-cycle wake-up pulse |
| win_flag | output | 1 | Base count is in its top quarter |

## Verification
The hardest case to reach is a service that coincides with the very tick that would expire the period. Only the tick count reveals it, so the bench counts exactly 255 ticks from a known restart and then drives the 256th tick and `clr` in the same cycle. It then counts a full fresh period to prove that the restart won. The window boundary is swept over every base count from 0 to 255. Each pass starts from a fresh restart, and the bench checks both the flag and the accept-or-reset outcome of the clear at that count.

// File: rtl/wdog_pkg.sv
// Shared definitions for the windowed watchdog.
// Assumes: all strobes are synchronous to the one system clock.
package wdog_pkg;
    // Action decided for the current cycle.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_RESET = 2'd2,
        ACT_WAKE  = 2'd3
    } wdog_act_e;
endpackage

// File: rtl/wdog_base_cnt.sv
// Base counter: advances once per tick and wraps at 2^W.
// Reports a wrap on the tick that overflows it, and whether the count
// sits in its top quarter (both upper bits set).
// Assumes: W >= 2; zero has priority over adv.
module wdog_base_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero,
    input  logic         adv,
    output logic         wrap,
    output logic         top_q
);
    logic [W-1:0] cnt;

    // Count ticks, restarting on request.
    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Wrap on the tick taking the count past all ones.
    assign wrap  = adv && (&cnt);
    // Top quarter: the two most significant bits are both one.
    assign top_q = &cnt[W-1:W-2];
endmodule

// File: rtl/wdog_postscale.sv
// Postscaler: counts base-counter wraps and flags expiry when the
// low sel bits of its count are all ones as another wrap arrives.
// The period is 2^sel wraps.
// Assumes: sel below 2^SEL_W; zero has priority over step.
module wdog_postscale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int PW = (1 << SEL_W) - 1;

    logic [PW-1:0] cnt;
    logic [PW-1:0] mask;

    // One mask bit per postscaler stage, set below the selected tap.
    generate
        for (genvar i = 0; i < PW; i++) begin : g_mask
            assign mask[i] = (SEL_W'(i) < sel);
        end
    endgenerate

    // Count wraps, restarting on request.
    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expire when the selected low bits are saturated on a new wrap.
    assign expire = step && ((cnt & mask) == mask);
endmodule

// File: rtl/wdog_event_ctl.sv
// Event arbiter: decides per cycle between restart, reset request and
// wake-up. It registers the two pulse outputs and drives the restart
// of both counters.
// Assumes: single-cycle strobes; disabled means counters held at zero.
module wdog_event_ctl
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic win_mode_n,
    input  logic clr,
    input  logic sleep_enter,
    input  logic freq_chg,
    input  logic clk_fail,
    input  logic top_q,
    input  logic expire,
    input  logic asleep,
    output logic zero,
    output logic rst_req,
    output logic wake
);
    wdog_act_e act;
    logic      viol;
    logic      restart;

    // Early service in window mode is a fault.
    assign viol    = clr && !win_mode_n && !top_q;
    assign restart = clr || sleep_enter || freq_chg || clk_fail;

    // Priority: disabled, window fault, restart, timeout.
    always_comb begin
        act = ACT_NONE;
        if (!en) begin
            act = ACT_NONE;
        end else if (viol) begin
            act = ACT_RESET;
        end else if (restart) begin
            act = ACT_CLEAR;
        end else if (expire) begin
            act = asleep ? ACT_WAKE : ACT_RESET;
        end
    end

    assign zero = !en || (act != ACT_NONE);

    // Register the one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            wake    <= 1'b0;
        end else begin
            rst_req <= (act == ACT_RESET);
            wake    <= (act == ACT_WAKE);
        end
    end
endmodule

// File: rtl/wdog_win.sv
// Windowed watchdog top: base counter, postscaler and event arbiter.
// Assumes: tick and all event strobes are single-cycle, synchronous.
module wdog_win #(
    parameter int BASE_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             win_mode_n,
    input  logic             clr,
    input  logic             sleep_enter,
    input  logic             freq_chg,
    input  logic             clk_fail,
    input  logic             asleep,
    output logic             rst_req,
    output logic             wake,
    output logic             win_flag
);
    logic en;
    logic zero;
    logic wrap;
    logic top_q;
    logic expire;

    // Hard enable overrides the software bit.
    assign en = hw_en || sw_en;

    wdog_base_cnt #(.W(BASE_W)) u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .zero  (zero),
        .adv   (tick),
        .wrap  (wrap),
        .top_q (top_q)
    );

    wdog_postscale #(.SEL_W(SEL_W)) u_post (
        .clk    (clk),
        .rst_n  (rst_n),
        .zero   (zero),
        .step   (wrap),
        .sel    (ps_sel),
        .expire (expire)
    );

    wdog_event_ctl u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .win_mode_n  (win_mode_n),
        .clr         (clr),
        .sleep_enter (sleep_enter),
        .freq_chg    (freq_chg),
        .clk_fail    (clk_fail),
        .top_q       (top_q),
        .expire      (expire),
        .asleep      (asleep),
        .zero        (zero),
        .rst_req     (rst_req),
        .wake        (wake)
    );

    // Flag reads zero whenever the watchdog is off.
    assign win_flag = en && top_q;
endmodule

// File: rtl/wdog_win_chk.sv
// Port-level property checker for wdog_win, attached by bind.
module wdog_win_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic hw_en,
    input logic sw_en,
    input logic win_mode_n,
    input logic clr,
    input logic sleep_enter,
    input logic freq_chg,
    input logic clk_fail,
    input logic asleep,
    input logic rst_req,
    input logic wake,
    input logic win_flag
);
    // R8: never both pulses at once
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake));

    // R8: wake pulse lasts one cycle
    a_r8_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);

    // R8: wake only follows a cycle spent asleep
    a_r8_wake_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(asleep));

    // R2: disabled cycle leaves everything quiet next cycle
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en || sw_en) |=> (!rst_req && !wake && !win_flag));

    // R5: restart events drop the window flag
    a_r5_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_en || sw_en) && (sleep_enter || freq_chg || clk_fail)) |=> !win_flag);

    // R4: the flag rises only as a result of a tick
    a_r4_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_flag) |-> $past(tick));

    // R6: early service in window mode raises a reset request
    a_r6_violation: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_en || sw_en) && !win_mode_n && clr && !win_flag) |=> rst_req);
endmodule

bind wdog_win wdog_win_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .hw_en       (hw_en),
    .sw_en       (sw_en),
    .win_mode_n  (win_mode_n),
    .clr         (clr),
    .sleep_enter (sleep_enter),
    .freq_chg    (freq_chg),
    .clk_fail    (clk_fail),
    .asleep      (asleep),
    .rst_req     (rst_req),
    .wake        (wake),
    .win_flag    (win_flag)
);

// File: tb/sim_wdog_win.sv
module sim_wdog_win;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hw_en = 1'b0;
    logic       sw_en = 1'b0;
    logic [3:0] ps_sel = 4'd0;
    logic       win_mode_n = 1'b1;
    logic       clr = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       freq_chg = 1'b0;
    logic       clk_fail = 1'b0;
    logic       asleep = 1'b0;
    logic       rst_req;
    logic       wake;
    logic       win_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    wdog_win u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hw_en(hw_en), .sw_en(sw_en),
        .ps_sel(ps_sel), .win_mode_n(win_mode_n), .clr(clr),
        .sleep_enter(sleep_enter), .freq_chg(freq_chg), .clk_fail(clk_fail),
        .asleep(asleep), .rst_req(rst_req), .wake(wake), .win_flag(win_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock; strobes dropped 1 time unit after the edge.
    task automatic cyc();
        @(posedge clk);
        #1;
        tick = 0; clr = 0; sleep_enter = 0; freq_chg = 0; clk_fail = 0;
    endtask

    task automatic restart();
        freq_chg = 1; cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; cyc();
        end
    endtask

    // Apply up to maxn ticks; record first tick index giving each pulse.
    task automatic tick_until(input int maxn, output int f_rst, output int f_wake,
                              output int c_rst, output int c_wake);
        f_rst = -1; f_wake = -1; c_rst = 0; c_wake = 0;
        for (int i = 1; i <= maxn; i++) begin
            tick = 1; cyc();
            if (rst_req) begin c_rst++;  if (f_rst  < 0) f_rst  = i; end
            if (wake)    begin c_wake++; if (f_wake < 0) f_wake = i; end
        end
    endtask

    initial begin
        #(CLK_PER * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int fr, fw, cr, cw;
        cyc(); cyc();
        rst_n = 1; cyc();
        check("R2 reset rst_req", rst_req, 0);
        check("R2 reset wake", wake, 0);
        check("R2 reset win_flag", win_flag, 0);

        // R2: disabled, nothing happens
        tick_until(600, fr, fw, cr, cw);
        check("R2 disabled no reset", cr, 0);
        ticks(200);
        check("R2 disabled flag", win_flag, 0);

        // R3 sweep over small selects, window mode off
        hw_en = 1;
        for (int s = 0; s < 6; s++) begin
            ps_sel = 4'(s);
            restart();
            tick_until((256 << s) + 4, fr, fw, cr, cw);
            check("R3 timeout tick", fr, 256 << s);
            check("R8 single reset pulse", cr, 1);
            check("R8 no wake when awake", cw, 0);
        end

        // R1: software enable alone, then hard enable with software 0
        ps_sel = 0;
        hw_en = 0; sw_en = 1; restart();
        tick_until(260, fr, fw, cr, cw);
        check("R1 sw enable runs", fr, 256);
        hw_en = 1; sw_en = 0; restart();
        tick_until(260, fr, fw, cr, cw);
        check("R1 hw enable overrides", fr, 256);

        // R4/R6: window sweep over every base count
        ps_sel = 1; win_mode_n = 0;
        for (int k = 0; k < 256; k++) begin
            restart();
            ticks(k);
            check("R4 window flag", win_flag, (k >= 192) ? 1 : 0);
            clr = 1; cyc();
            check("R6 early clear resets", rst_req, (k < 192) ? 1 : 0);
            check("R5 clear restarts", win_flag, 0);
        end

        // R6: after a violation the count restarts from zero
        ps_sel = 0; restart();
        ticks(50); clr = 1; cyc();
        check("R6 violation pulse", rst_req, 1);
        tick_until(260, fr, fw, cr, cw);
        check("R6 restart after violation", fr, 256);

        // R7: window mode off, early clear accepted
        win_mode_n = 1; restart();
        ticks(10); clr = 1; cyc();
        check("R7 no reset on clear", rst_req, 0);
        tick_until(260, fr, fw, cr, cw);
        check("R7 count restarted", fr, 256);

        // R5: each restart source
        for (int src = 0; src < 4; src++) begin
            restart();
            ticks(200);
            check("R5 flag before event", win_flag, 1);
            case (src)
                0: clr = 1;
                1: sleep_enter = 1;
                2: freq_chg = 1;
                default: clk_fail = 1;
            endcase
            cyc();
            check("R5 flag after event", win_flag, 0);
            tick_until(260, fr, fw, cr, cw);
            check("R5 full period after event", fr, 256);
        end

        // R8: asleep gives wake pulse instead
        asleep = 1; restart();
        tick_until(260, fr, fw, cr, cw);
        check("R8 wake tick", fw, 256);
        check("R8 single wake", cw, 1);
        check("R8 no reset while asleep", cr, 0);
        asleep = 0;

        // R9: clear coincident with expiring tick wins
        win_mode_n = 0; restart();
        ticks(255);
        tick = 1; clr = 1; cyc();
        check("R9 clear beats timeout", rst_req, 0);
        tick_until(260, fr, fw, cr, cw);
        check("R9 fresh period", fr, 256);
        win_mode_n = 1;

        // R2: disabling mid-count restarts
        restart(); ticks(200);
        hw_en = 0; cyc();
        check("R2 flag when off", win_flag, 0);
        hw_en = 1;
        tick_until(260, fr, fw, cr, cw);
        check("R2 full period after re-enable", fr, 256);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule